// File: doc/BRIEF.md
# Watchdog Timer With Power-Mode Gating

This block watches for a periodic refresh from software and raises a one-cycle reset pulse when the refresh does not arrive in time. The timeout is one of four power-of-two lengths, chosen through a mode register that can only be written. The count source can be the system (crystal) clock itself, or a slow on-board RC oscillator. That oscillator reaches the block as a level signal. The block synchronizes this signal into the system clock domain and counts each rising edge of it.

Two power-mode inputs, halt and stop, can each freeze the count. Whether each one does so is set by its own bit in the mode register. When the watchdog fires, its own pulse puts the mode register back to its power-on values. After a timeout the block therefore always restarts from the same known configuration.

Mode byte layout: bits [1:0] select the timeout, bit 2 lets the count run during halt, bit 3 lets it run during stop, bit 4 selects the crystal clock (1) or the RC source (0), and bits [7:5] are reserved.

Top module: `wdt_power_gated`

## Requirements
- R1: With mode bits [1:0] = 0, 1, 2 or 3, the block produces a reset pulse after exactly 2^TAP_LOG0, 2^TAP_LOG1, 2^TAP_LOG2 or 2^TAP_LOG3 counted ticks after a refresh (defaults 256, 512, 1024, 4096). The pulse appears on wdt_rst in the cycle after the last counted clock edge.
- R2: After reset, wdt_rst is low and the mode register holds timeout select 1, run-during-halt on, run-during-stop on, and the RC source selected.
- R3: A refresh clears the count to zero, and it takes priority over a timeout in the same cycle, so no pulse is produced.
- R4: Each reset pulse is exactly one clock wide. The count restarts from zero after it, so a second timeout follows after a full period without any refresh.
- R5: With mode bit 2 at 0, the count holds its value in every cycle in which halt is high. With bit 2 at 1, halt has no effect.
- R6: With mode bit 3 at 0, the count holds its value in every cycle in which stop is high. With bit 3 at 1, stop has no effect.
- R7: With mode bit 4 at 1, every system clock edge is a tick. With bit 4 at 0, only a rising edge of rc_tick is a tick: it passes through two synchronizer flops and adds one count two clock edges after it is sampled, and clock edges alone add nothing.
- R8: A write whose bits [7:5] are not all zero leaves the mode register unchanged.
- R9: A watchdog reset pulse reloads the mode register with the values listed in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (crystal) clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 8 | Mode register write value |
| refresh | input | 1 | Software refresh strobe, clears the count |
| halt | input | 1 | Core is in halt mode |
| stop | input | 1 | Core is in stop mode |
| rc_tick | input | 1 | RC oscillator output, asynchronous level |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The assertions assume that the smallest timeout is at least two ticks. They also assume that refresh, writes and the power-mode inputs are synchronous to clk, and that rc_tick stays at each level for at least two clock periods so that the synchronizer sees every edge. The bench drives every input on the falling clock edge. It holds rc_tick high for two cycles and then low for two cycles per RC period. It uses tap lengths of 4 to 32 so that every timeout, gating combination and reserved bit can be swept.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        TAP_SHORT   = 2'd0,
        TAP_NORMAL  = 2'd1,
        TAP_LONG    = 2'd2,
        TAP_LONGEST = 2'd3
    } tap_sel_e;

    localparam int NUM_TAPS = 2 ** $bits(tap_sel_e);

    typedef struct packed {
        logic     src_xtal;
        logic     stop_run;
        logic     halt_run;
        tap_sel_e tap;
    } wdt_mode_t;

    localparam int MODE_W = $bits(wdt_mode_t);

    localparam wdt_mode_t MODE_DEFAULT = '{
        src_xtal: 1'b0,
        stop_run: 1'b1,
        halt_run: 1'b1,
        tap:      TAP_NORMAL
    };

    function automatic logic reserved_clear(input logic [REG_W-1:0] d);
        return (d >> MODE_W) == '0;
    endfunction

    function automatic wdt_mode_t decode_mode(input logic [REG_W-1:0] d);
        return wdt_mode_t'(d[MODE_W-1:0]);
    endfunction

    function automatic int pick_log(input int idx, input int l0, input int l1,
                                    input int l2, input int l3);
        case (idx)
            0:       return l0;
            1:       return l1;
            2:       return l2;
            default: return l3;
        endcase
    endfunction

    function automatic int max_log(input int l0, input int l1, input int l2, input int l3);
        int m;
        m = l0;
        if (l1 > m) m = l1;
        if (l2 > m) m = l2;
        if (l3 > m) m = l3;
        return m;
    endfunction

endpackage

// File: rtl/wdt_mode_reg.sv
module wdt_mode_reg
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             reload,
    output wdt_mode_t        mode_o
);

    wdt_mode_t mode_q;

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            mode_q <= MODE_DEFAULT;
        end else if (wr_en && reserved_clear(wr_data)) begin
            mode_q <= decode_mode(wr_data);
        end
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/wdt_tick_src.sv
module wdt_tick_src
    import wdt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rc_tick,
    input  wdt_mode_t mode,
    input  logic      halt,
    input  logic      stop,
    output logic      tick_o
);

    logic [SYNC_STAGES:0] sync_q;
    logic                 rc_rise;
    logic                 frozen;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-1:0], rc_tick};
        end
    end

    assign rc_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
    assign frozen  = (halt & ~mode.halt_run) | (stop & ~mode.stop_run);

    generate
        if (SYNC_STAGES < 1) begin : g_bad_sync
            initial $error("SYNC_STAGES must be at least 1");
        end
    endgenerate

    always_comb begin
        if (frozen) begin
            tick_o = 1'b0;
        end else if (mode.src_xtal) begin
            tick_o = 1'b1;
        end else begin
            tick_o = rc_rise;
        end
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int TAP_LOG0 = 8,
    parameter int TAP_LOG1 = 9,
    parameter int TAP_LOG2 = 10,
    parameter int TAP_LOG3 = 12,
    parameter int CNT_W    = max_log(TAP_LOG0, TAP_LOG1, TAP_LOG2, TAP_LOG3)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             refresh,
    input  tap_sel_e         tap,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] limit_o,
    output logic             hit_o,
    output logic             fire_o
);

    logic [CNT_W-1:0] lim_tab [NUM_TAPS];
    logic [CNT_W-1:0] cnt_q;
    logic             fire_q;

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_lim
        localparam int LOG = pick_log(i, TAP_LOG0, TAP_LOG1, TAP_LOG2, TAP_LOG3);
        assign lim_tab[i] = CNT_W'((64'd1 << LOG) - 64'd1);
    end

    assign limit_o = lim_tab[tap];
    assign hit_o   = tick & ~refresh & (cnt_q >= limit_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            fire_q <= 1'b0;
        end else begin
            fire_q <= hit_o;
            if (refresh || hit_o) begin
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign count_o = cnt_q;
    assign fire_o  = fire_q;

endmodule

// File: rtl/wdt_power_gated.sv
module wdt_power_gated
    import wdt_pkg::*;
#(
    parameter int TAP_LOG0    = 8,
    parameter int TAP_LOG1    = 9,
    parameter int TAP_LOG2    = 10,
    parameter int TAP_LOG3    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       refresh,
    input  logic       halt,
    input  logic       stop,
    input  logic       rc_tick,
    output logic       wdt_rst
);

    localparam int CNT_W = max_log(TAP_LOG0, TAP_LOG1, TAP_LOG2, TAP_LOG3);

    wdt_mode_t        mode_q;
    logic             tick;
    logic             hit;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] limit;

    wdt_mode_reg u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .reload  (hit),
        .mode_o  (mode_q)
    );

    wdt_tick_src #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tick (
        .clk     (clk),
        .rst     (rst),
        .rc_tick (rc_tick),
        .mode    (mode_q),
        .halt    (halt),
        .stop    (stop),
        .tick_o  (tick)
    );

    wdt_counter #(
        .TAP_LOG0 (TAP_LOG0),
        .TAP_LOG1 (TAP_LOG1),
        .TAP_LOG2 (TAP_LOG2),
        .TAP_LOG3 (TAP_LOG3),
        .CNT_W    (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .refresh (refresh),
        .tap     (mode_q.tap),
        .count_o (count),
        .limit_o (limit),
        .hit_o   (hit),
        .fire_o  (wdt_rst)
    );

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic             refresh,
    input logic             halt,
    input logic             stop,
    input wdt_mode_t        mode,
    input logic [CNT_W-1:0] count,
    input logic             wdt_rst
);

    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |=> !wdt_rst);

    assert_restart_zero_R4: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |-> count == '0);

    assert_refresh_clears_R3: assert property (@(posedge clk) disable iff (rst)
        refresh |=> (count == '0 && !wdt_rst));

    assert_defaults_reload_R9: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |-> mode == MODE_DEFAULT);

    assert_halt_freeze_R5: assert property (@(posedge clk) disable iff (rst)
        (halt && !mode.halt_run && !refresh) |=> $stable(count));

    assert_stop_freeze_R6: assert property (@(posedge clk) disable iff (rst)
        (stop && !mode.stop_run && !refresh) |=> $stable(count));

    assert_reserved_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[7:5] != 3'b000) |=> ($stable(mode) || wdt_rst));

endmodule

bind wdt_power_gated wdt_checker #(
    .CNT_W (CNT_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .refresh (refresh),
    .halt    (halt),
    .stop    (stop),
    .mode    (mode_q),
    .count   (count),
    .wdt_rst (wdt_rst)
);

// File: tb/sim_wdt_power_gated.sv
`timescale 1ns/1ps
module sim_wdt_power_gated;

    localparam int L0 = 2;
    localparam int L1 = 3;
    localparam int L2 = 4;
    localparam int L3 = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       refresh = 1'b0;
    logic       halt = 1'b0;
    logic       stop = 1'b0;
    logic       rc_tick = 1'b0;
    logic       wdt_rst;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int wide   = 0;
    int expect_p = 0;
    bit prev_hi = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdt_power_gated #(
        .TAP_LOG0 (L0), .TAP_LOG1 (L1), .TAP_LOG2 (L2), .TAP_LOG3 (L3),
        .SYNC_STAGES (2)
    ) u0 (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_data (wr_data),
        .refresh (refresh), .halt (halt), .stop (stop),
        .rc_tick (rc_tick), .wdt_rst (wdt_rst)
    );

    always @(posedge clk) begin
        #5;
        if (wdt_rst === 1'b1) begin
            pulses++;
            if (prev_hi) wide++;
        end
        prev_hi = (wdt_rst === 1'b1);
    end

    function automatic int tap_len(input int t);
        case (t)
            0:       return 1 << L0;
            1:       return 1 << L1;
            2:       return 1 << L2;
            default: return 1 << L3;
        endcase
    endfunction

    function automatic logic [7:0] mk_mode(input bit xtal, input bit run_stop,
                                           input bit run_halt, input int t);
        return {3'b000, xtal, run_stop, run_halt, 2'(t)};
    endfunction

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_refresh();
        refresh = 1'b1;
        @(negedge clk);
        refresh = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic rc_cycle(input int n);
        for (int i = 0; i < n; i++) begin
            rc_tick = 1'b1;
            step(2);
            rc_tick = 1'b0;
            step(2);
        end
    endtask

    task automatic setup(input logic [7:0] d);
        do_refresh();
        do_write(d);
        do_refresh();
    endtask

    task automatic check_pulses(input string req, input string what);
        checks++;
        if (pulses != expect_p) begin
            errors++;
            $display("FAIL %s (%s): pulse count %0d, expected %0d", req, what, pulses, expect_p);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            checks++;
            if (wide != 0) begin
                errors++;
                $display("FAIL R4: wide pulses %0d, expected 0", wide);
            end
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, cycles 200000 expected fewer");
        finish_run();
    end

    initial begin
        @(negedge clk);
        step(3);
        checks++;
        if (wdt_rst !== 1'b0) begin
            errors++;
            $display("FAIL R2: wdt_rst in reset %b, expected 0", wdt_rst);
        end
        rst = 1'b0;
        step(2);
        checks++;
        if (wdt_rst !== 1'b0) begin
            errors++;
            $display("FAIL R2: wdt_rst after reset %b, expected 0", wdt_rst);
        end

        // R2 / R7: defaults: RC source, tap 1, counting through halt and stop
        halt = 1'b1;
        stop = 1'b1;
        do_refresh();
        step(50);
        check_pulses("R7", "clock edges alone in RC mode");
        rc_cycle(tap_len(1) - 1);
        check_pulses("R2", "default tap one short");
        rc_cycle(1);
        expect_p++;
        check_pulses("R2", "default tap reached with halt and stop high");
        halt = 1'b0;
        stop = 1'b0;

        // R1 / R9: sweep every tap on the crystal source
        for (int t = 0; t < 4; t++) begin
            setup(mk_mode(1'b1, 1'b1, 1'b1, t));
            step(tap_len(t) - 1);
            check_pulses("R1", "one tick before timeout");
            step(1);
            expect_p++;
            check_pulses("R1", "timeout reached");
            step(3 * tap_len(3));
            check_pulses("R9", "mode reloaded to RC source");
            rc_cycle(tap_len(1) - 1);
            check_pulses("R9", "reloaded tap one short");
            rc_cycle(1);
            expect_p++;
            check_pulses("R9", "reloaded tap reached");
        end

        // R4: restart without refresh after a pulse
        do_write(mk_mode(1'b1, 1'b1, 1'b1, 0));
        step(tap_len(0) - 1);
        check_pulses("R4", "restart one short");
        step(1);
        expect_p++;
        check_pulses("R4", "restart timeout");

        // R3: refresh on the terminal cycle wins
        for (int t = 0; t < 2; t++) begin
            setup(mk_mode(1'b1, 1'b1, 1'b1, t));
            step(tap_len(t) - 1);
            do_refresh();
            check_pulses("R3", "refresh on terminal cycle");
            step(tap_len(t) - 1);
            check_pulses("R3", "after refresh one short");
            step(1);
            expect_p++;
            check_pulses("R3", "after refresh timeout");
        end

        // R5 / R6: gating sweep over halt and stop with run bits on and off
        for (int g = 0; g < 2; g++) begin
            for (int run = 0; run < 2; run++) begin
                int pre;
                pre = 3;
                setup(mk_mode(1'b1, (g == 1) ? run[0] : 1'b1, (g == 0) ? run[0] : 1'b1, 1));
                step(pre);
                if (g == 0) halt = 1'b1; else stop = 1'b1;
                if (run == 1) begin
                    step(tap_len(1) - pre);
                    expect_p++;
                    check_pulses(g == 0 ? "R5" : "R6", "run bit set keeps counting");
                    halt = 1'b0;
                    stop = 1'b0;
                end else begin
                    step(20);
                    halt = 1'b0;
                    stop = 1'b0;
                    check_pulses(g == 0 ? "R5" : "R6", "frozen during mode");
                    step(tap_len(1) - pre - 1);
                    check_pulses(g == 0 ? "R5" : "R6", "resumed one short");
                    step(1);
                    expect_p++;
                    check_pulses(g == 0 ? "R5" : "R6", "resumed timeout");
                end
            end
        end

        // R7: explicit RC selection with tap 0
        setup(mk_mode(1'b0, 1'b1, 1'b1, 0));
        step(100);
        check_pulses("R7", "no RC edges");
        rc_cycle(tap_len(0) - 1);
        check_pulses("R7", "RC one short");
        rc_cycle(1);
        expect_p++;
        check_pulses("R7", "RC timeout");

        // R8: each reserved bit blocks the write
        for (int b = 5; b < 8; b++) begin
            do_refresh();
            do_write(mk_mode(1'b1, 1'b1, 1'b1, 0));
            do_write(mk_mode(1'b0, 1'b0, 1'b0, 3) | (8'h01 << b));
            do_refresh();
            step(tap_len(0) - 1);
            check_pulses("R8", "old mode one short");
            step(1);
            expect_p++;
            check_pulses("R8", "old mode kept");
        end

        step(4);
        finish_run();
    end

endmodule